// File: doc/BRIEF.md
# Saturating Block and Error Counter Pair with Coherent Read

This block keeps two 16-bit status counters for a pseudo-random test-pattern receiver. One counter advances once for every pattern block the checker reports. The other advances once for every block the checker flags as errored. Neither counter wraps: each one stops at all-ones and stays there.

Software reaches the counters through a small read port that has an address, a read strobe and a read data bus. Reading the block-count address captures both live counters together into snapshot registers, and that read returns the block value. A later read of the error-count address returns the error value captured at that same instant, and it then clears both live counters. This two-step sequence gives software a matched pair of figures, so it can compute an error ratio without the counters moving between the two reads.

Read data is registered. It appears in the cycle after the read strobe and holds until the next read.

Top module: `blk_cnt_pair`

## Requirements
- R1: Each cycle with `blk_stb` high adds one to the live block counter, and each cycle with `err_stb` high adds one to the live error counter.
- R2: A live counter that has reached all-ones (65535) stays at that value on further strobes and never wraps to zero.
- R3: A read at address 0xCC05 returns, on `rd_data` in the next cycle, the live block count as it stood in the read cycle. The same read snapshots the live error count from that cycle.
- R4: A read at address 0xCC06 returns, on `rd_data` in the next cycle, the error snapshot taken by the most recent 0xCC05 read. If no such read has happened since reset, it returns zero.
- R5: A read at 0xCC06 clears both live counters. A strobe in that same cycle makes its counter restart at 1 instead of 0.
- R6: A read at any other address returns zero. It leaves the live counters and the snapshots unchanged.
- R7: As long as `err_stb` is only asserted together with `blk_stb`, the live error count never exceeds the live block count.
- R8: Reset sets both live counters, both snapshots and `rd_data` to zero.
- R9: While `rd_en` is low, `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_stb | input | 1 | One pulse per received pattern block |
| err_stb | input | 1 | One pulse per received errored block |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read address |
| rd_data | output | 16 | Registered read data |

## Verification
The checker assumes the input constraint behind R7: the error strobe is only asserted in a cycle where the block strobe is also asserted. It checks this constraint as a property of its own, so that a failure of the error-bound property can be traced to the stimulus or to the design. The bench drives the error strobe only as a subset of block cycles. The bench also issues at most one read per cycle, which is all the port allows.

// File: rtl/blk_cnt_pkg.sv
package blk_cnt_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_BLK  = 2'd1,
      SEL_ERR  = 2'd2
   } rd_sel_e;
endpackage

// File: rtl/cnt_sat_cell.sv
module cnt_sat_cell #(
   parameter int W   = 16,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] LIMIT = '1;
   localparam logic [W-1:0] ONE   = W'(1);

   logic at_lim;

   generate
      if (SAT) begin : g_sat
         assign at_lim = (q == LIMIT);
      end else begin : g_wrap
         assign at_lim = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)               q <= '0;
      else if (clr)             q <= inc ? ONE : '0;
      else if (inc && !at_lim)  q <= q + ONE;
   end
endmodule

// File: rtl/cnt_snap_rd.sv
module cnt_snap_rd
   import blk_cnt_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_en,
   input  rd_sel_e      sel,
   input  logic [W-1:0] blk_live,
   input  logic [W-1:0] err_live,
   output logic         clr,
   output logic [W-1:0] snap_err,
   output logic [W-1:0] rd_data
);
   logic [W-1:0] snap_blk;
   rd_sel_e      last_sel;

   assign clr = rd_en && (sel == SEL_ERR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_blk <= '0;
         snap_err <= '0;
         last_sel <= SEL_NONE;
      end else if (rd_en) begin
         last_sel <= sel;
         if (sel == SEL_BLK) begin
            snap_blk <= blk_live;
            snap_err <= err_live;
         end
      end
   end

   always_comb begin
      unique case (last_sel)
         SEL_BLK: rd_data = snap_blk;
         SEL_ERR: rd_data = snap_err;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/blk_cnt_pair.sv
module blk_cnt_pair
   import blk_cnt_pkg::*;
#(
   parameter int              CNT_W    = 16,
   parameter int              ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] BLK_ADDR = 16'hCC05,
   parameter logic [ADDR_W-1:0] ERR_ADDR = 16'hCC06,
   parameter bit              SAT      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_stb,
   input  logic              err_stb,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data
);
   localparam int NCNT = 2;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("blk_cnt_pair: CNT_W must be at least 2");
      end
      if (BLK_ADDR == ERR_ADDR) begin : g_bad_a
         $error("blk_cnt_pair: addresses must differ");
      end
      if (!SAT) begin : g_bad_s
         $error("blk_cnt_pair: counters must saturate");
      end
   endgenerate

   rd_sel_e           sel;
   logic              clr;
   logic [CNT_W-1:0]  snap_err;
   logic [NCNT-1:0]   inc;
   logic [CNT_W-1:0]  cnt_q [NCNT];

   always_comb begin
      if (rd_addr == BLK_ADDR)      sel = SEL_BLK;
      else if (rd_addr == ERR_ADDR) sel = SEL_ERR;
      else                          sel = SEL_NONE;
   end

   assign inc = {err_stb, blk_stb};

   for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      cnt_sat_cell #(.W(CNT_W), .SAT(SAT)) u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .inc  (inc[i]),
         .clr  (clr),
         .q    (cnt_q[i])
      );
   end

   cnt_snap_rd #(.W(CNT_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .sel     (sel),
      .blk_live(cnt_q[0]),
      .err_live(cnt_q[1]),
      .clr     (clr),
      .snap_err(snap_err),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/blk_cnt_pair_chk.sv
module blk_cnt_pair_chk #(
   parameter int                CNT_W    = 16,
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] BLK_ADDR = 16'hCC05,
   parameter logic [ADDR_W-1:0] ERR_ADDR = 16'hCC06
) (
   input logic              clk,
   input logic              rst_n,
   input logic              blk_stb,
   input logic              err_stb,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [CNT_W-1:0]  rd_data,
   input logic [CNT_W-1:0]  blk_q,
   input logic [CNT_W-1:0]  err_q,
   input logic [CNT_W-1:0]  snap_err
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic clr_rd, blk_rd;
   assign clr_rd = rd_en && (rd_addr == ERR_ADDR);
   assign blk_rd = rd_en && (rd_addr == BLK_ADDR);

   p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_stb && !clr_rd && blk_q != TOP) |=> blk_q == $past(blk_q) + CNT_W'(1));

   p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_q == TOP && !clr_rd) |=> blk_q == TOP);

   p_err_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q == TOP && !clr_rd) |=> err_q == TOP);

   p_blk_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      blk_rd |=> rd_data == $past(blk_q));

   p_snap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      blk_rd |=> snap_err == $past(err_q));

   p_err_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_rd |=> rd_data == $past(snap_err));

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_rd |=> (blk_q == CNT_W'($past(blk_stb))) && (err_q == CNT_W'($past(err_stb))));

   p_other_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !clr_rd && !blk_rd) |=> rd_data == '0);

   p_in_err_blk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_stb |-> blk_stb);

   p_err_le_blk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_q <= blk_q);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

bind blk_cnt_pair blk_cnt_pair_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BLK_ADDR(BLK_ADDR), .ERR_ADDR(ERR_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb), .err_stb(err_stb),
   .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
   .blk_q(cnt_q[0]), .err_q(cnt_q[1]), .snap_err(snap_err)
);

// File: tb/blk_cnt_pair_bench.sv
module blk_cnt_pair_bench;
   localparam logic [15:0] A_BLK = 16'hCC05;
   localparam logic [15:0] A_ERR = 16'hCC06;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_stb = 1'b0, err_stb = 1'b0, rd_en = 1'b0;
   logic [15:0] rd_addr = '0;
   logic [15:0] rd_data;

   int n_chk = 0, n_err = 0;
   int m_blk = 0, m_err = 0, s_err = 0;
   int exp_rd = 0;

   always #2 clk = ~clk;

   blk_cnt_pair u_blk_cnt_pair (
      .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb), .err_stb(err_stb),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sat_inc(int v);
      return (v >= 65535) ? 65535 : v + 1;
   endfunction

   // one clock: drive at negedge, update model, sample after the edge
   task automatic cyc(bit b, bit e, bit rd, logic [15:0] a);
      bit clr;
      @(negedge clk);
      blk_stb = b; err_stb = e; rd_en = rd; rd_addr = a;
      clr = rd && (a == A_ERR);
      if (rd) begin
         if (a == A_BLK) begin exp_rd = m_blk; s_err = m_err; end
         else if (a == A_ERR) exp_rd = s_err;
         else exp_rd = 0;
      end
      if (clr) begin m_blk = b ? 1 : 0; m_err = e ? 1 : 0; end
      else begin
         if (b) m_blk = sat_inc(m_blk);
         if (e) m_err = sat_inc(m_err);
      end
      @(posedge clk); #1;
      blk_stb = 0; err_stb = 0; rd_en = 0;
   endtask

   task automatic rd_chk(logic [15:0] a, string req);
      cyc(0, 0, 1, a);
      check(req, int'(rd_data), exp_rd);
   endtask

   initial begin
      #700000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R8: reset state
      check("R8 rd_data after reset", int'(rd_data), 0);
      rd_chk(A_ERR, "R8 R4 err snapshot zero after reset");
      rd_chk(A_BLK, "R8 blk zero after reset");
      rd_chk(A_ERR, "R8 err zero after reset");

      // R1/R3/R4/R5: sweep of block/error patterns
      for (int p = 1; p < 8; p++) begin
         for (int k = 0; k < 3 * p + 2; k++) cyc(1, (k % p) == 0, 0, 16'h0);
         rd_chk(A_BLK, "R1 R3 block read");
         cyc(1, 1, 0, 16'h0);
         rd_chk(A_ERR, "R4 error snapshot coherent");
         rd_chk(A_BLK, "R5 cleared block");
         rd_chk(A_ERR, "R5 cleared error");
      end

      // R9: data holds without reads
      cyc(1, 0, 0, 16'h0);
      rd_chk(A_BLK, "R3 block read");
      for (int k = 0; k < 4; k++) cyc(1, 1, 0, 16'h0);
      check("R9 rd_data holds", int'(rd_data), 1);

      // R5: strobes during clearing read restart at 1
      cyc(1, 1, 1, A_ERR);
      check("R4 err via clearing read", int'(rd_data), exp_rd);
      rd_chk(A_BLK, "R5 block restarts at 1");
      rd_chk(A_ERR, "R5 error restarts at 1");
      cyc(1, 0, 1, A_ERR);
      rd_chk(A_BLK, "R5 block restart only");
      rd_chk(A_ERR, "R5 error stays 0");

      // R6: other addresses read zero and do not disturb
      for (int k = 0; k < 5; k++) cyc(1, k[0], 0, 16'h0);
      rd_chk(A_BLK, "R3 block before other reads");
      rd_chk(16'hCC04, "R6 other addr zero");
      rd_chk(16'hCC07, "R6 other addr zero");
      rd_chk(16'h0000, "R6 other addr zero");
      rd_chk(A_ERR, "R6 snapshot kept");
      rd_chk(A_BLK, "R6 no clear by other addr");

      // R2: saturate both counters
      for (int k = 0; k < 65540; k++) cyc(1, 1, 0, 16'h0);
      rd_chk(A_BLK, "R2 block saturated");
      check("R2 block at all-ones", int'(rd_data), 65535);
      rd_chk(A_ERR, "R2 error saturated");
      check("R2 error at all-ones", int'(rd_data), 65535);
      rd_chk(A_BLK, "R5 cleared after saturation");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule